// File: doc/BRIEF.md
# Port Statistics Snapshot Unit

This block keeps a set of live event counters for each of several switch ports and lets a host freeze one port's counters into a snapshot buffer, then fetch the frozen values one entry at a time. Every counter advances by one for each pulse on its own increment input. The host talks to the block through a small register window. It writes a command word to the operation register, polls that register's busy bit, and then collects a 32-bit result as two 16-bit halves.

A capture command copies the selected port's counters into the snapshot buffer, one entry per clock cycle. A read command moves one snapshot entry into the result registers. Each counter is either narrow (one entry wide) or wide (two entries wide). A wide counter uses two neighbouring entries: the less significant word sits at the even index and the more significant word at the next index. Live counting never stops. The host therefore gets a consistent picture of one port while traffic continues.

Top module: `port_stat_snapshot`

## Requirements
- R1: After a synchronous active-low reset, all live counters and all snapshot entries are zero, the busy bit is clear and both result registers read zero.
- R2: Each cycle in which increment input bit `p*NUM_CNT + c` is high adds one to counter c of port p. A narrow counter wraps modulo 2^ENT_W and a wide counter wraps modulo 2^(2*ENT_W).
- R3: A write to address 0x1d with bits 15:10 equal to 6'b110111 and bits 9:0 holding a port number below NUM_PORTS starts a capture of that port. Bit 15 of address 0x1d then reads as 1 for exactly NUM_ENT cycles, one per entry, which is within 10 polls for the default sizes.
- R4: A write to address 0x1d with bits 15:10 equal to 6'b110011 and bits 9:0 holding an index below NUM_ENT sets busy for exactly one cycle. After that, the snapshot entry, zero-extended to 32 bits, can be read with bits 31:16 at address 0x1e and bits 15:0 at address 0x1f.
- R5: Entries 0 to 2*NUM_WIDE-1 hold the wide counters: wide counter w has its low word at entry 2w and its high word at entry 2w+1. Both words come from the same cycle. Entries from 2*NUM_WIDE upward hold the narrow counters in counter order.
- R6: Increments that arrive while a capture runs still reach the live counters. They do not change snapshot entries that were already taken.
- R7: The following writes are ignored and leave busy, the result registers and the snapshot buffer unchanged: writes to address 0x1d whose bits 15:10 match neither command, commands with an out-of-range port or index, any command written while busy is set, and writes to addresses 0x1e and 0x1f.
- R8: The snapshot holds its contents until the next accepted capture. Repeated reads of an entry return the same value, and each port's counters are independent of the other ports' counters.
- R9: Address 0x1d reads the busy bit in bit 15 and zero in bits 14:0. Any address other than 0x1d, 0x1e and 0x1f reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_i | input | NUM_PORTS*(NUM_WIDE+NUM_NARROW) | One increment pulse per port and counter, bit p*NUM_CNT+c |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i (combinational) |

## Verification
The bench builds the block with NUM_PORTS=3, NUM_WIDE=2, NUM_NARROW=3 and ENT_W=10. With these values a narrow counter wraps after 1024 pulses and the low word of a wide counter carries into its high word within a few thousand cycles, so the wrap rule of R2 and the word pairing of R5 can be reached directly. Three ports make port number 3 a legal-looking but out-of-range argument. Seven entries make index 7 the first rejected read index and keep the capture busy window at seven cycles, so its exact length is checked against the polling bound.

// File: rtl/port_stat_pkg.sv
// Shared constants and types for the port statistics snapshot unit.
// Assumes a 5-bit register address and a 16-bit register data path.
package port_stat_pkg;

    localparam logic [5:0] OPC_CAPTURE = 6'b110111;
    localparam logic [5:0] OPC_READ    = 6'b110011;

    localparam logic [4:0] ADDR_OP     = 5'h1d;
    localparam logic [4:0] ADDR_RES_HI = 5'h1e;
    localparam logic [4:0] ADDR_RES_LO = 5'h1f;

    localparam int unsigned POLL_LIMIT = 10;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_READ    = 2'd2
    } op_state_e;

endpackage

// File: rtl/port_stat_live_bank.sv
// Live counter bank: one counter per port and counter slot.
// Slots below NUM_WIDE are wide (2*ENT_W bits), the rest are narrow (ENT_W bits).
// Assumes sel_port/sel_cnt are in range when the selected value is used.
module port_stat_live_bank #(
    parameter int NUM_PORTS  = 4,
    parameter int NUM_WIDE   = 2,
    parameter int NUM_NARROW = 5,
    parameter int ENT_W      = 32,
    parameter int PORT_W     = 2,
    parameter int CNT_W      = 3
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_PORTS*(NUM_WIDE+NUM_NARROW)-1:0] inc,
    input  logic [PORT_W-1:0]                         sel_port,
    input  logic [CNT_W-1:0]                          sel_cnt,
    output logic [2*ENT_W-1:0]                        sel_val
);
    localparam int NUM_CNT = NUM_WIDE + NUM_NARROW;
    localparam int TOTAL   = NUM_PORTS * NUM_CNT;
    localparam int FLAT_W  = (TOTAL > 1) ? $clog2(TOTAL) + 1 : 1;

    logic [2*ENT_W-1:0] cnt_flat [TOTAL];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
            if (c < NUM_WIDE) begin : g_wide
                logic [2*ENT_W-1:0] value;
                // Count increment pulses on a wide counter, wrapping naturally.
                always_ff @(posedge clk) begin
                    if (!rst_n)                  value <= '0;
                    else if (inc[p*NUM_CNT + c]) value <= value + 1'b1;
                end
                assign cnt_flat[p*NUM_CNT + c] = value;
            end else begin : g_narrow
                logic [ENT_W-1:0] value;
                // Count increment pulses on a narrow counter, wrapping naturally.
                always_ff @(posedge clk) begin
                    if (!rst_n)                  value <= '0;
                    else if (inc[p*NUM_CNT + c]) value <= value + 1'b1;
                end
                assign cnt_flat[p*NUM_CNT + c] = {{ENT_W{1'b0}}, value};
            end
        end
    end

    logic [FLAT_W-1:0] flat_idx;

    // Pick the selected port's selected counter for the snapshot path.
    always_comb begin
        flat_idx = FLAT_W'(sel_port) * FLAT_W'(NUM_CNT) + FLAT_W'(sel_cnt);
        sel_val  = '0;
        if (int'(flat_idx) < TOTAL) sel_val = cnt_flat[flat_idx];
    end

    AST_LIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc[0] |=> cnt_flat[0] == $past(cnt_flat[0]) + 1'b1) else $error("live step"); // R2
    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc[0] |=> $stable(cnt_flat[0])) else $error("live hold"); // R2

endmodule

// File: rtl/port_stat_snap_buf.sv
// Snapshot buffer: NUM_ENT entries of ENT_W bits with one write port that
// can fill one entry or an adjacent pair, plus one combinational read port.
// Assumes wr_idx and rd_idx are below NUM_ENT whenever they are used.
module port_stat_snap_buf #(
    parameter int NUM_ENT = 9,
    parameter int ENT_W   = 32,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_pair,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [2*ENT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENT_W-1:0]   rd_data
);
    logic [ENT_W-1:0] snap [NUM_ENT];

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        // Store the low word at wr_idx and, for a pair, the high word above it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                snap[e] <= '0;
            else if (wr_en && int'(wr_idx) == e)
                snap[e] <= wr_data[ENT_W-1:0];
            else if (wr_en && wr_pair && int'(wr_idx) + 1 == e)
                snap[e] <= wr_data[2*ENT_W-1:ENT_W];
        end
    end

    // Return the addressed entry, zero when out of range.
    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NUM_ENT) rd_data = snap[rd_idx];
    end

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(snap[0])) else $error("snapshot changed"); // R8

endmodule

// File: rtl/port_stat_op_ctrl.sv
// Operation controller: decodes host command writes, sequences a capture one
// entry per cycle, performs single-entry reads into the 32-bit result register.
// Assumes ENT_W <= 32 and that increments are only counted by the live bank.
module port_stat_op_ctrl
    import port_stat_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int NUM_WIDE   = 2,
    parameter int NUM_NARROW = 5,
    parameter int ENT_W      = 32,
    parameter int PORT_W     = 2,
    parameter int CNT_W      = 3,
    parameter int IDX_W      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [4:0]         reg_addr,
    input  logic [15:0]        reg_wdata,
    output logic               busy,
    output logic [31:0]        result,
    output logic [PORT_W-1:0]  sel_port,
    output logic [CNT_W-1:0]   sel_cnt,
    input  logic [2*ENT_W-1:0] sel_val,
    output logic               snap_wr_en,
    output logic               snap_wr_pair,
    output logic [IDX_W-1:0]   snap_wr_idx,
    output logic [2*ENT_W-1:0] snap_wr_data,
    output logic [IDX_W-1:0]   snap_rd_idx,
    input  logic [ENT_W-1:0]   snap_rd_data
);
    localparam int NUM_ENT = 2 * NUM_WIDE + NUM_NARROW;

    op_state_e         st;
    logic [PORT_W-1:0] cap_port;
    logic [IDX_W-1:0]  cur_idx;
    logic              accept;
    logic              cmd_capture;
    logic              cmd_read;
    logic              ent_wide;
    logic              ent_hi;
    logic              last_ent;

    // Decode a command write that the controller is free to take.
    always_comb begin
        accept      = reg_wr && (reg_addr == ADDR_OP) && (st == ST_IDLE);
        cmd_capture = accept && (reg_wdata[15:10] == OPC_CAPTURE) &&
                      (reg_wdata[9:0] < 10'(NUM_PORTS));
        cmd_read    = accept && (reg_wdata[15:10] == OPC_READ) &&
                      (reg_wdata[9:0] < 10'(NUM_ENT));
        last_ent    = (int'(cur_idx) == NUM_ENT - 1);
    end

    // Advance the command state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cap_port <= '0;
            cur_idx  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (cmd_capture) begin
                        st       <= ST_CAPTURE;
                        cap_port <= PORT_W'(reg_wdata[9:0]);
                        cur_idx  <= '0;
                    end else if (cmd_read) begin
                        st      <= ST_READ;
                        cur_idx <= IDX_W'(reg_wdata[9:0]);
                    end
                end
                ST_CAPTURE: begin
                    cur_idx <= cur_idx + 1'b1;
                    if (last_ent) st <= ST_IDLE;
                end
                ST_READ:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Latch the addressed snapshot entry at the end of a read command.
    always_ff @(posedge clk) begin
        if (!rst_n)             result <= '0;
        else if (st == ST_READ) result <= 32'(snap_rd_data);
    end

    // Map the current entry index to its counter slot and word half.
    always_comb begin
        ent_wide = (int'(cur_idx) < 2 * NUM_WIDE);
        if (ent_wide) begin
            sel_cnt = CNT_W'(cur_idx >> 1);
            ent_hi  = cur_idx[0];
        end else begin
            sel_cnt = CNT_W'(int'(cur_idx) - NUM_WIDE);
            ent_hi  = 1'b0;
        end
    end

    // Drive the snapshot write port; a wide pair is written at its low entry.
    always_comb begin
        busy         = (st != ST_IDLE);
        sel_port     = cap_port;
        snap_wr_en   = (st == ST_CAPTURE) && !ent_hi;
        snap_wr_pair = ent_wide;
        snap_wr_idx  = cur_idx;
        snap_wr_data = sel_val;
        snap_rd_idx  = cur_idx;
    end

    AST_CAPTURE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_CAPTURE |-> int'(cur_idx) < NUM_ENT) else $error("capture index"); // R3
    AST_CAPTURE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_CAPTURE |-> NUM_ENT - int'(cur_idx) <= int'(POLL_LIMIT)) else $error("poll bound"); // R3
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_READ |=> st == ST_IDLE) else $error("read length"); // R4
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CAPTURE && !last_ent && reg_wr) |=>
            (st == ST_CAPTURE && cap_port == $past(cap_port))) else $error("busy write taken"); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_READ |=> $stable(result)) else $error("result changed"); // R7

endmodule

// File: rtl/port_stat_snapshot.sv
// Top of the port statistics snapshot unit: live counters, snapshot buffer,
// command controller and the host register read mux.
// Assumes ENT_W between 1 and 32 and at least one counter per port.
module port_stat_snapshot
    import port_stat_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int NUM_WIDE   = 2,
    parameter int NUM_NARROW = 5,
    parameter int ENT_W      = 32
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic [NUM_PORTS*(NUM_WIDE+NUM_NARROW)-1:0] inc_i,
    input  logic                                       reg_wr_i,
    input  logic [4:0]                                 reg_addr_i,
    input  logic [15:0]                                reg_wdata_i,
    output logic [15:0]                                reg_rdata_o
);
    localparam int NUM_CNT = NUM_WIDE + NUM_NARROW;
    localparam int NUM_ENT = 2 * NUM_WIDE + NUM_NARROW;
    localparam int PORT_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int CNT_W   = (NUM_CNT > 1)   ? $clog2(NUM_CNT)   : 1;
    localparam int IDX_W   = (NUM_ENT > 1)   ? $clog2(NUM_ENT)   : 1;

    logic               busy;
    logic [31:0]        result;
    logic [PORT_W-1:0]  sel_port;
    logic [CNT_W-1:0]   sel_cnt;
    logic [2*ENT_W-1:0] sel_val;
    logic               snap_wr_en;
    logic               snap_wr_pair;
    logic [IDX_W-1:0]   snap_wr_idx;
    logic [2*ENT_W-1:0] snap_wr_data;
    logic [IDX_W-1:0]   snap_rd_idx;
    logic [ENT_W-1:0]   snap_rd_data;

    port_stat_live_bank #(
        .NUM_PORTS(NUM_PORTS), .NUM_WIDE(NUM_WIDE), .NUM_NARROW(NUM_NARROW),
        .ENT_W(ENT_W), .PORT_W(PORT_W), .CNT_W(CNT_W)
    ) u_live (
        .clk(clk), .rst_n(rst_n), .inc(inc_i),
        .sel_port(sel_port), .sel_cnt(sel_cnt), .sel_val(sel_val)
    );

    port_stat_snap_buf #(
        .NUM_ENT(NUM_ENT), .ENT_W(ENT_W), .IDX_W(IDX_W)
    ) u_snap (
        .clk(clk), .rst_n(rst_n),
        .wr_en(snap_wr_en), .wr_pair(snap_wr_pair), .wr_idx(snap_wr_idx),
        .wr_data(snap_wr_data), .rd_idx(snap_rd_idx), .rd_data(snap_rd_data)
    );

    port_stat_op_ctrl #(
        .NUM_PORTS(NUM_PORTS), .NUM_WIDE(NUM_WIDE), .NUM_NARROW(NUM_NARROW),
        .ENT_W(ENT_W), .PORT_W(PORT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr_i), .reg_addr(reg_addr_i), .reg_wdata(reg_wdata_i),
        .busy(busy), .result(result),
        .sel_port(sel_port), .sel_cnt(sel_cnt), .sel_val(sel_val),
        .snap_wr_en(snap_wr_en), .snap_wr_pair(snap_wr_pair),
        .snap_wr_idx(snap_wr_idx), .snap_wr_data(snap_wr_data),
        .snap_rd_idx(snap_rd_idx), .snap_rd_data(snap_rd_data)
    );

    // Host register read mux: busy flag and the two result halves.
    always_comb begin
        case (reg_addr_i)
            ADDR_OP:     reg_rdata_o = {busy, 15'd0};
            ADDR_RES_HI: reg_rdata_o = result[31:16];
            ADDR_RES_LO: reg_rdata_o = result[15:0];
            default:     reg_rdata_o = 16'd0;
        endcase
    end

    AST_OP_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr_i == ADDR_OP |-> reg_rdata_o[14:0] == 15'd0) else $error("op bits"); // R9

endmodule

// File: tb/port_stat_snapshot_tb.sv
module port_stat_snapshot_tb;
    localparam int NP   = 3;
    localparam int NW   = 2;
    localparam int NN   = 3;
    localparam int EW   = 10;
    localparam int NC   = NW + NN;
    localparam int NE   = 2 * NW + NN;
    localparam longint unsigned LO_MASK   = (64'd1 << EW) - 1;
    localparam longint unsigned WIDE_MASK = (64'd1 << (2 * EW)) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*NC-1:0]  inc = '0;
    logic              reg_wr = 1'b0;
    logic [4:0]        reg_addr = 5'h1d;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint unsigned live [NP][NC];
    longint unsigned snapm [NC];
    logic [31:0]     last_res;

    always #10 clk = ~clk;

    port_stat_snapshot #(.NUM_PORTS(NP), .NUM_WIDE(NW), .NUM_NARROW(NN), .ENT_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .inc_i(inc), .reg_wr_i(reg_wr),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
    );

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic longint unsigned exp_entry(input int e);
        if (e < 2 * NW) return (e % 2 == 1) ? (snapm[e/2] >> EW) & LO_MASK : snapm[e/2] & LO_MASK;
        return snapm[e - NW] & LO_MASK;
    endfunction

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [15:0] d;
        n = 0;
        rd_reg(5'h1d, d);
        while (d[15] && n < 20) begin
            n++;
            @(negedge clk);
            rd_reg(5'h1d, d);
        end
    endtask

    task automatic drive_inc(input logic [NP*NC-1:0] v);
        @(negedge clk);
        inc = v;
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NC; c++)
                if (v[p*NC + c])
                    live[p][c] = (live[p][c] + 1) & ((c < NW) ? WIDE_MASK : LO_MASK);
    endtask

    task automatic capture(input int p, input string tag);
        int n;
        for (int c = 0; c < NC; c++) snapm[c] = live[p][c];
        wr_reg(5'h1d, 16'hdc00 | 16'(p));
        wait_idle(n);
        check({tag, " busy cycles of capture"}, n, NE);
    endtask

    task automatic read_entry(input int e, output logic [31:0] v);
        int n;
        logic [15:0] hi, lo;
        wr_reg(5'h1d, 16'hcc00 | 16'(e));
        wait_idle(n);
        check("R4 busy cycles of read", n, 1);
        rd_reg(5'h1e, hi);
        rd_reg(5'h1f, lo);
        v = {hi, lo};
        last_res = v;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        for (int e = 0; e < NE; e++) begin
            read_entry(e, v);
            check(tag, v, exp_entry(e));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [31:0] v;
        int n;
        void'($urandom(32'd1234));
        for (int p = 0; p < NP; p++) for (int c = 0; c < NC; c++) live[p][c] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R9 read mux
        rd_reg(5'h1d, d); check("R1 busy after reset", d, 16'h0000);
        rd_reg(5'h1e, d); check("R1 result hi after reset", d, 0);
        rd_reg(5'h1f, d); check("R1 result lo after reset", d, 0);
        rd_reg(5'h05, d); check("R9 unmapped address", d, 0);
        for (int c = 0; c < NC; c++) snapm[c] = 0;
        check_all("R1 snapshot zero after reset");

        // R2 R3 R5 R8 random increment rounds with captures of random ports
        for (int r = 0; r < 8; r++) begin
            int cyc = 20 + int'($urandom % 60);
            int p = int'($urandom % NP);
            for (int k = 0; k < cyc; k++) drive_inc(NP*NC'($urandom & $urandom));
            drive_inc('0);
            capture(p, "R3");
            check_all("R2 R8 random snapshot entry");
        end

        // R8 repeated reads return the same value
        read_entry(2, v);
        check("R8 repeat read", v, exp_entry(2));

        // R2 R5 wrap: port 1 wide counter 0 and narrow counter NW
        for (int k = 0; k < 1100; k++) drive_inc(((NP*NC)'(1) << (1*NC + 0)) | ((NP*NC)'(1) << (1*NC + NW)));
        drive_inc('0);
        capture(1, "R3");
        read_entry(0, v); check("R5 wide low word", v, exp_entry(0));
        read_entry(1, v); check("R5 wide high word", v, exp_entry(1));
        check("R5 high word nonzero after carry", (v != 0), 1);
        read_entry(2*NW, v); check("R2 narrow wrap", v, exp_entry(2*NW));

        // R6 increments during capture do not disturb taken entries
        for (int c = 0; c < NC; c++) snapm[c] = live[2][c];
        wr_reg(5'h1d, 16'hdc02);
        for (int k = 0; k < 3; k++) drive_inc((NP*NC)'(1) << (2*NC + 0));
        drive_inc('0);
        wait_idle(n);
        read_entry(0, v); check("R6 snapshot not disturbed low", v, exp_entry(0));
        read_entry(1, v); check("R6 snapshot not disturbed high", v, exp_entry(1));
        capture(2, "R6");
        read_entry(0, v); check("R6 live counter kept counting", v, exp_entry(0));

        // R7 ignored writes: bad opcode, out of range, other addresses
        wr_reg(5'h1d, 16'hdc00 | 16'(NP));
        rd_reg(5'h1d, d); check("R7 out-of-range port no busy", d, 0);
        wr_reg(5'h1d, 16'hcc00 | 16'(NE));
        rd_reg(5'h1d, d); check("R7 out-of-range index no busy", d, 0);
        wr_reg(5'h1d, 16'hfc01);
        rd_reg(5'h1d, d); check("R7 bad opcode no busy", d, 0);
        wr_reg(5'h1e, 16'h1234);
        wr_reg(5'h1f, 16'h5678);
        rd_reg(5'h1e, d); check("R7 result hi unchanged", d, last_res[31:16]);
        rd_reg(5'h1f, d); check("R7 result lo unchanged", d, last_res[15:0]);
        check_all("R7 snapshot unchanged by ignored writes");

        // R7 commands while busy are ignored
        for (int k = 0; k < 7; k++) drive_inc(NP*NC'($urandom));
        drive_inc('0);
        for (int c = 0; c < NC; c++) snapm[c] = live[0][c];
        wr_reg(5'h1d, 16'hdc00);
        wr_reg(5'h1d, 16'hdc01);
        wr_reg(5'h1d, 16'hcc00);
        wait_idle(n);
        rd_reg(5'h1e, d); check("R7 read while busy ignored hi", d, last_res[31:16]);
        rd_reg(5'h1f, d); check("R7 read while busy ignored lo", d, last_res[15:0]);
        check_all("R7 capture while busy ignored");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule